// File: doc/BRIEF.md
# Out-of-Band Status Responder

This block serves a peripheral that asks the host, over an out-of-band message channel, for one of two status items: the most recent temperature sample, or the current real-time-clock date and time. A free-running interval timer sets when the block copies the live temperature byte, the seven live clock bytes and three format flags into a set of internal snapshot registers. The block never reads the live inputs byte by byte while it answers a request.

A request is a one-cycle `req_valid` strobe carrying a destination code. If the code selects temperature or clock, the block sends a posted response, one byte per cycle, on `rsp_data`. The response starts with the destination code as a header and is followed by the payload, all drawn from a single snapshot. The snapshot registers are frozen while a response is being sent, so a packet can never combine the seconds of one capture with the minutes or hours of another. If the code selects neither item, the block sends no response and pulses `unsup_req`.

Top module: `oob_status_responder`

## Requirements
- R1: While reset is asserted, and until the first capture after it, `rsp_valid`, `rsp_last` and `unsup_req` are 0 and every snapshot byte and flag reads as 0.
- R2: Counting from the first clock edge after the internal reset releases, the snapshot takes the live inputs on every CAP_PERIOD-th edge, provided no response is in progress on that edge.
- R3: A capture that falls due while a response is in progress is held back. It is performed on the first edge at which no response is in progress. The snapshot does not change between the first and the last byte of a response.
- R4: A request with `req_dest == TEMP_DEST` produces a 2-byte response: TEMP_DEST, then the snapshot temperature.
- R5: A request with `req_dest == RTC_DEST` produces a 9-byte response: RTC_DEST, the flag byte, then seconds, minutes, hours, day of week, day of month, month and year. These are taken from `rtc_live` bits [7:0], [15:8], [23:16], [31:24], [39:32], [47:40] and [55:48] respectively.
- R6: The flag byte is {5'b0, bin_flag, h24_flag, dst_flag}: bit 0 means daylight saving is already applied, bit 1 means 24-hour format, and bit 2 means binary data (0 means BCD). The flags are captured together with the time bytes.
- R7: The hours byte is passed through unchanged. In 12-hour format (bit 1 of the flag byte at 0), its bit 7 set (PM) arrives at the peripheral as sent.
- R8: A request whose destination matches neither code produces no response. One cycle after it, `unsup_req` is 1 for exactly one cycle.
- R9: A request that arrives while a response is in progress is ignored. It does not restart or lengthen the packet and does not raise `unsup_req`.
- R10: `rsp_valid` stays high for consecutive cycles across a whole packet. `rsp_last` is high only on its final byte, and `rsp_valid` is low in the cycle after that.
- R11: The header byte appears on `rsp_valid`/`rsp_data` in the cycle right after the edge that samples an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| temp_live | input | 8 | Live temperature byte from the sensor side |
| rtc_live | input | 56 | Live clock bytes, seconds in the low byte through year in the high byte |
| dst_flag | input | 1 | Daylight saving already applied |
| h24_flag | input | 1 | Hours byte is in 24-hour format |
| bin_flag | input | 1 | Time bytes are binary rather than BCD |
| req_valid | input | 1 | One-cycle request strobe |
| req_dest | input | 8 | Requested destination code |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |
| unsup_req | output | 1 | Pulse for a request to an unknown destination |

## Verification
The bench builds the block with CAP_PERIOD set to 16 instead of the default of about one millisecond of clocks. At that setting a capture falls due every few packets, and often in the middle of a 9-byte clock response. This exercises the deferred-capture path many times. The live clock bytes change on every cycle, so any packet that mixed two snapshots would show a mismatch against the reference queue. Requests held high continuously also reach the ignored-while-busy case and the back-to-back packet case.

// File: rtl/oob_resp_pkg.sv
package oob_resp_pkg;
  localparam int RTC_BYTES = 7;
  localparam int TEMP_LEN  = 2;
  localparam int RTC_LEN   = 2 + RTC_BYTES;
  localparam int IDX_W     = $clog2(RTC_LEN);

  typedef enum logic {KIND_TEMP = 1'b0, KIND_RTC = 1'b1} rsp_kind_e;

  typedef struct packed {
    logic [7:0]             temp;
    logic [8*RTC_BYTES-1:0] rtc;
    logic                   dst;
    logic                   h24;
    logic                   bin;
  } snap_t;
endpackage

// File: rtl/oob_rst_sync.sv
module oob_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/oob_capture_ctrl.sv
module oob_capture_ctrl
  import oob_resp_pkg::*;
#(
  parameter int CAP_PERIOD = 200000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  busy,
  input  snap_t live,
  output snap_t snap
);
  localparam int CNT_W = (CAP_PERIOD > 1) ? $clog2(CAP_PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAP_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             tick, cap_en;
  snap_t            snap_q;

  always_comb begin
    tick   = (cnt_q == CNT_LAST);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    cap_en = (tick | pend_q) & ~busy;
    pend_d = (tick | pend_q) & busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_q <= '0;
    else if (cap_en) snap_q <= live;
  end

  assign snap = snap_q;
endmodule

// File: rtl/oob_tx_serializer.sv
module oob_tx_serializer
  import oob_resp_pkg::*;
#(
  parameter logic [7:0] TEMP_DEST = 8'h21,
  parameter logic [7:0] RTC_DEST  = 8'h22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_dest,
  input  snap_t      snap,
  output logic       busy,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_last,
  output logic       unsup_req
);
  rsp_kind_e        kind_q, kind_d;
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_idx;
  logic             unsup_q, unsup_d;
  logic             hit_temp, hit_rtc;
  logic [7:0]       rtc_pkt [RTC_LEN];

  assign hit_temp = (req_dest == TEMP_DEST);
  assign hit_rtc  = (req_dest == RTC_DEST);
  assign last_idx = (kind_q == KIND_RTC) ? IDX_W'(RTC_LEN - 1) : IDX_W'(TEMP_LEN - 1);

  always_comb begin
    busy_d  = busy_q;
    kind_d  = kind_q;
    idx_d   = idx_q;
    unsup_d = 1'b0;
    if (!busy_q) begin
      if (req_valid) begin
        if (hit_temp || hit_rtc) begin
          busy_d = 1'b1;
          kind_d = hit_rtc ? KIND_RTC : KIND_TEMP;
          idx_d  = '0;
        end else begin
          unsup_d = 1'b1;
        end
      end
    end else if (idx_q == last_idx) begin
      busy_d = 1'b0;
    end else begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      kind_q  <= KIND_TEMP;
      idx_q   <= '0;
      unsup_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
      unsup_q <= unsup_d;
    end
  end

  assign rtc_pkt[0] = RTC_DEST;
  assign rtc_pkt[1] = {5'b0, snap.bin, snap.h24, snap.dst};
  for (genvar g = 0; g < RTC_BYTES; g++) begin : g_rtc_byte
    assign rtc_pkt[g+2] = snap.rtc[8*g +: 8];
  end

  always_comb begin
    if (kind_q == KIND_RTC) rsp_data = rtc_pkt[idx_q];
    else                    rsp_data = (idx_q == '0) ? TEMP_DEST : snap.temp;
  end

  assign busy      = busy_q;
  assign rsp_valid = busy_q;
  assign rsp_last  = busy_q && (idx_q == last_idx);
  assign unsup_req = unsup_q;
endmodule

// File: rtl/oob_status_responder.sv
module oob_status_responder
  import oob_resp_pkg::*;
#(
  parameter int         CAP_PERIOD = 200000,
  parameter logic [7:0] TEMP_DEST  = 8'h21,
  parameter logic [7:0] RTC_DEST   = 8'h22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  temp_live,
  input  logic [55:0] rtc_live,
  input  logic        dst_flag,
  input  logic        h24_flag,
  input  logic        bin_flag,
  input  logic        req_valid,
  input  logic [7:0]  req_dest,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        rsp_last,
  output logic        unsup_req
);
  logic  rst_sync_n;
  logic  busy;
  snap_t live, snap_q;

  assign live = '{temp: temp_live, rtc: rtc_live, dst: dst_flag, h24: h24_flag, bin: bin_flag};

  oob_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  oob_capture_ctrl #(.CAP_PERIOD(CAP_PERIOD)) u_cap (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .busy  (busy),
    .live  (live),
    .snap  (snap_q)
  );

  oob_tx_serializer #(.TEMP_DEST(TEMP_DEST), .RTC_DEST(RTC_DEST)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_dest  (req_dest),
    .snap      (snap_q),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .unsup_req (unsup_req)
  );
endmodule

// File: rtl/oob_resp_checker.sv
module oob_resp_checker
  import oob_resp_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  req_valid,
  input logic  rsp_valid,
  input logic  rsp_last,
  input logic  unsup_req,
  input snap_t snap
);
  a_r10_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  a_r10_last_ends_packet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> !rsp_valid);

  a_r11_start_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid));

  a_r9_unsup_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_req |-> !$past(rsp_valid));

  a_r8_unsup_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_req |-> !rsp_valid);

  a_r3_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rsp_valid)) |-> $stable(snap));
endmodule

bind oob_status_responder oob_resp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_last  (rsp_last),
  .unsup_req (unsup_req),
  .snap      (snap_q)
);

// File: tb/oob_status_responder_tb_top.sv
module oob_status_responder_tb_top;
  localparam int         P    = 16;
  localparam logic [7:0] TD   = 8'h21;
  localparam logic [7:0] RD   = 8'h22;
  localparam int         WDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  temp_live = 8'h00;
  logic [55:0] rtc_live = '0;
  logic        dst_flag = 1'b0, h24_flag = 1'b0, bin_flag = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_dest = 8'h00;
  logic        rsp_valid, rsp_last, unsup_req;
  logic [7:0]  rsp_data;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  logic  hold = 1'b0;
  logic  done = 1'b0;

  always #2.5 clk = ~clk;

  oob_status_responder #(.CAP_PERIOD(P), .TEMP_DEST(TD), .RTC_DEST(RD)) dut_i (
    .clk(clk), .rst_n(rst_n), .temp_live(temp_live), .rtc_live(rtc_live),
    .dst_flag(dst_flag), .h24_flag(h24_flag), .bin_flag(bin_flag),
    .req_valid(req_valid), .req_dest(req_dest),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last), .unsup_req(unsup_req)
  );

  task automatic check(input string t, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // Reference model: captured values, a period counter and a queue of pending bytes
  logic [7:0]  m_temp;
  logic [55:0] m_rtc;
  logic [2:0]  m_flags;
  logic [7:0]  q[$];
  int          m_cnt, m_rel;
  bit          m_pend, m_unsup;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_temp = 0; m_rtc = 0; m_flags = 0; q.delete();
      m_cnt = 0; m_rel = 0; m_pend = 0; m_unsup = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit tick, was_busy;
      tick     = (m_cnt == P - 1);
      m_cnt    = tick ? 0 : m_cnt + 1;
      was_busy = (q.size() != 0);
      if ((tick || m_pend) && !was_busy) begin
        m_temp = temp_live; m_rtc = rtc_live;
        m_flags = {bin_flag, h24_flag, dst_flag};
        m_pend = 0;
      end else if (tick) begin
        m_pend = 1;
      end
      m_unsup = 0;
      if (was_busy) void'(q.pop_front());
      else if (req_valid) begin
        if (req_dest == TD) begin
          q.push_back(TD); q.push_back(m_temp);
        end else if (req_dest == RD) begin
          q.push_back(RD); q.push_back({5'b0, m_flags});
          for (int i = 0; i < 7; i++) q.push_back(m_rtc[8*i +: 8]);
        end else m_unsup = 1;
      end
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit ev;
      ev = (q.size() != 0);
      check(tag, "rsp_valid (R10)", rsp_valid, ev);
      check(tag, "rsp_last (R10)", rsp_last, ev && q.size() == 1);
      check(tag, "unsup_req (R8)", unsup_req, m_unsup);
      if (ev) check(tag, "rsp_data (R5)", rsp_data, q[0]);
    end
  end

  // Live stimulus: clock bytes change every cycle unless held
  always @(negedge clk) begin
    cyc++;
    if (!hold) begin
      temp_live <= 8'(cyc * 3 + 1);
      for (int i = 0; i < 7; i++) rtc_live[8*i +: 8] <= 8'(cyc * (i + 2) + i);
    end
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk); req_valid = 1'b1; req_dest = d;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    idle(3);
    // R1: outputs idle in reset
    check("R1", "rsp_valid in reset", rsp_valid, 0);
    check("R1", "unsup_req in reset", unsup_req, 0);
    rst_n = 1'b1;
    idle(3);
    send(TD);                       // R1: snapshot still zero, R4 format
    idle(4);

    tag = "R2/R4";
    idle(40); send(TD); idle(4);
    tag = "R2/R5";
    send(RD); idle(12);

    tag = "R3/R9/R11";               // requests held high: ignored while busy, captures deferred
    @(negedge clk); req_valid = 1'b1; req_dest = RD;
    idle(70);
    req_dest = TD; idle(23);
    req_valid = 1'b0; idle(12);

    tag = "R8";
    send(8'h55); idle(2); send(8'h00);
    @(negedge clk); req_valid = 1'b1; req_dest = 8'hFF; idle(3); req_valid = 1'b0;
    send(RD); send(8'h77); idle(12);  // R9: unknown code while busy gives no pulse

    tag = "R6";
    for (int f = 0; f < 8; f++) begin
      {bin_flag, h24_flag, dst_flag} = 3'(f);
      idle(P + 3); send(RD); idle(10);
    end

    // R7: 12-hour PM hours byte passes unchanged
    tag = "R7";
    hold = 1'b1;
    @(negedge clk);
    rtc_live = 56'h23_11_15_04_92_30_45;
    {bin_flag, h24_flag, dst_flag} = 3'b000;
    idle(P + 3);
    send(RD);
    begin
      logic [7:0] got[9];
      for (int i = 0; i < 9; i++) begin
        got[i] = rsp_data;
        if (i < 8) @(negedge clk);
      end
      check("R7", "hours byte", got[4], 8'h92);
      check("R6", "flag byte", got[1], 8'h00);
      check("R5", "seconds byte", got[2], 8'h45);
      check("R5", "year byte", got[8], 8'h23);
    end
    idle(5);
    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", WDOG, WDOG);
    finish_run();
  end
endmodule